// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor Core

This core is a 32-bit processor with no arithmetic, jump or load instruction. Every instruction moves one value into an addressed register. Some of those registers are ordinary storage. Others are control or functional-unit registers, and writing one of them is what makes something happen:

- Writing the add trigger produces a sum.
- Writing the compare trigger latches a comparison flag.
- Writing the instruction pointer redirects fetch.
- Writing the data register performs a memory store.

The only conditional instruction is a move that a status bit suppresses. Software builds a branch by copying a compare flag into status and then doing a test-and-move into the instruction pointer.

The core fetches from a synchronous instruction ROM. Each instruction takes one fetch cycle and then one execute cycle. Data memory is reached through an address register and a data register. Reads of the data register return the external read bus. Writes to it pulse a write strobe.

A single interrupt input is latched as pending. When the pending request is taken, the core saves the return address and vectors to a programmable handler. Entry stays masked from reset and while a handler runs. Writing the return-target register re-enables entry, and software uses that same write to leave the setup code.

Top module: `mover_core`

## Requirements
- R1: Instruction bits 31:24 select the operation and bits 23:16 name the destination. Opcode 0xE0 copies the register named by bits 15:8 into the destination.
- R2: Opcode 0xD0 writes bits 15:0, zero-extended to 32 bits, into the destination.
- R3: Opcode 0xA0 acts as 0xE0 when bit 0 of the status register (address 0x01) is 0, and otherwise writes nothing. A write to 0x01 keeps only bit 0 of the value.
- R4: Any other opcode has no effect. A write to an unmapped address (for example 0x77) has no effect. Reading an unmapped address, or one of the trigger addresses 0x03, 0x0C, 0x17 or 0x32, returns 0.
- R5: After reset, the first fetch is from address 0 with the write strobe low. Every instruction takes exactly two cycles, and `rom_addr` is stable across them. Instruction number n (counting from 0) executes on clock edge 2n+1 after reset release.
- R6: Writing 0x02 makes the next fetch come from the written value. Reading 0x02 returns the address of the executing instruction.
- R7: Writing value v to 0x0C loads 0x0B with (contents of 0x0A) + v.
- R8: Writing value v to 0x17 loads 0x14 with 1 when v is greater than the contents of 0x13 as unsigned numbers, and with 0 otherwise. Equal values give 0.
- R9: Writing value v to 0x32 loads 0x31 with v + 1.
- R10: `dmem_addr` carries the low bits of register 0x04. A write to 0x05 drives `dmem_we` high for the execute cycle, with the value on `dmem_wdata`. A read of 0x05 returns `dmem_rdata`.
- R11: A pulse on `irq` is held pending. It is taken at the end of the first execute cycle that begins with the request pending and entry unmasked. When it is taken, 0x08 receives the address the next instruction would have come from, fetch moves to the address in 0x09, and entry is masked.
- R12: Entry is masked after reset and while a handler runs. Writing value v to 0x03 jumps to v and unmasks entry. A request arriving while masked waits until after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | PCW | Instruction fetch address |
| rom_data | input | 32 | Instruction word, registered by the ROM one edge after `rom_addr` |
| dmem_addr | output | DAW | Data memory word address |
| dmem_wdata | output | 32 | Data memory write value |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 32 | Data memory read value for `dmem_addr`, combinational |
| irq | input | 1 | Interrupt request |

## Verification
Every effect of instruction n falls on the execute edge 2n+1:

- a store strobe;
- the redirected fetch address;
- the interrupt vector and saved return address.

A functional-unit result written there is first read back by the following instruction. The bench timestamps each observed store by edge index and compares it with 2n+1, computed from the instruction count of a straight-line or jumping program.

The bench also places interrupt pulses on chosen edges. It derives the return address by counting instructions, which covers three cases:

- a request taken mid-loop;
- a request held through the setup code;
- a request held through a running handler.

// File: rtl/mover_core.sv
module mover_core #(
  parameter int PCW = 16,
  parameter int DAW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] rom_addr,
  input  logic [31:0]    rom_data,
  output logic [DAW-1:0] dmem_addr,
  output logic [31:0]    dmem_wdata,
  output logic           dmem_we,
  input  logic [31:0]    dmem_rdata,
  input  logic           irq
);
  localparam logic [7:0] OP_MOV = 8'hE0, OP_IMM = 8'hD0, OP_TST = 8'hA0;
  localparam logic [7:0] A_STAT = 8'h01, A_IP = 8'h02, A_RET = 8'h03, A_DP = 8'h04,
                         A_DD = 8'h05, A_SAV = 8'h08, A_VEC = 8'h09, A_BASE = 8'h0A,
                         A_SUM = 8'h0B, A_ADD = 8'h0C, A_CMPA = 8'h13, A_FLAG = 8'h14,
                         A_CMPT = 8'h17, A_INC = 8'h31, A_INCT = 8'h32,
                         A_R1 = 8'h41, A_R2 = 8'h42, A_R3 = 8'h43;
  localparam logic [PCW-1:0] PC_ONE = PCW'(1);

  logic           exec, stat, mask, pend, flag;
  logic [PCW-1:0] pc, saved, vec, nxt_pc;
  logic [DAW-1:0] dp;
  logic [31:0]    base, sum, cmp_a, inc, r1, r2, r3, rd_val, wval;

  wire [7:0]  op  = rom_data[31:24];
  wire [7:0]  dst = rom_data[23:16];
  wire [7:0]  src = rom_data[15:8];
  wire        wr   = exec && (op == OP_MOV || op == OP_IMM || (op == OP_TST && !stat));
  wire        jump = wr && (dst == A_IP || dst == A_RET);
  wire        take = exec && pend && !mask;

  always_comb begin
    case (src)
      A_STAT:  rd_val = {31'b0, stat};
      A_IP:    rd_val = 32'(pc);
      A_DP:    rd_val = 32'(dp);
      A_DD:    rd_val = dmem_rdata;
      A_SAV:   rd_val = 32'(saved);
      A_VEC:   rd_val = 32'(vec);
      A_BASE:  rd_val = base;
      A_SUM:   rd_val = sum;
      A_CMPA:  rd_val = cmp_a;
      A_FLAG:  rd_val = {31'b0, flag};
      A_INC:   rd_val = inc;
      A_R1:    rd_val = r1;
      A_R2:    rd_val = r2;
      A_R3:    rd_val = r3;
      default: rd_val = 32'b0;
    endcase
  end

  assign wval       = (op == OP_IMM) ? {16'b0, rom_data[15:0]} : rd_val;
  assign nxt_pc     = jump ? wval[PCW-1:0] : pc + PC_ONE;
  assign rom_addr   = pc;
  assign dmem_addr  = dp;
  assign dmem_wdata = wval;
  assign dmem_we    = wr && dst == A_DD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec <= 1'b0; pc <= '0; stat <= 1'b0; mask <= 1'b1; pend <= 1'b0;
      saved <= '0; vec <= '0; dp <= '0; base <= '0; sum <= '0; cmp_a <= '0;
      flag <= 1'b0; inc <= '0; r1 <= '0; r2 <= '0; r3 <= '0;
    end else begin
      exec <= !exec;
      pend <= take ? irq : (pend | irq);
      if (wr) begin
        case (dst)
          A_STAT: stat  <= wval[0];
          A_RET:  mask  <= 1'b0;
          A_DP:   dp    <= wval[DAW-1:0];
          A_VEC:  vec   <= wval[PCW-1:0];
          A_BASE: base  <= wval;
          A_ADD:  sum   <= base + wval;
          A_CMPA: cmp_a <= wval;
          A_CMPT: flag  <= wval > cmp_a;
          A_INC:  inc   <= wval;
          A_INCT: inc   <= wval + 32'd1;
          A_R1:   r1    <= wval;
          A_R2:   r2    <= wval;
          A_R3:   r3    <= wval;
          default: ;
        endcase
      end
      if (take) begin
        pc <= vec; saved <= nxt_pc; mask <= 1'b1;
      end else if (exec) begin
        pc <= nxt_pc;
      end
    end
  end

  assert_phase_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);
  assert_fetch_to_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> exec && $stable(rom_addr));
  assert_store_in_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> exec);
  assert_test_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_TST && stat) |-> !dmem_we);
  assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dst == A_IP && !take) |=> rom_addr == $past(wval[PCW-1:0]));
  assert_vector_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mask && rom_addr == $past(vec));
  assert_mask_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !(wr && dst == A_RET)) |=> mask);
endmodule

// File: tb/mover_core_tb.sv
module mover_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 16, DAW = 16;

  logic           clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
  logic [PCW-1:0] rom_addr;
  logic [31:0]    rom_data, dmem_wdata, dmem_rdata;
  logic [DAW-1:0] dmem_addr;
  logic           dmem_we;

  logic [31:0] rom [64];
  logic [31:0] mem [16];
  int          cyc, wcnt;
  logic [15:0] wl_a [32];
  logic [31:0] wl_d [32];
  int          wl_e [32];
  int          tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  mover_core #(.PCW(PCW), .DAW(DAW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .irq(irq));

  always @(posedge clk) rom_data <= rom[rom_addr[5:0]];
  assign dmem_rdata = mem[dmem_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; wcnt <= 0; mem[3] <= 32'hCAFEF00D;
    end else begin
      if (dmem_we) begin
        mem[dmem_addr[3:0]] <= dmem_wdata;
        if (wcnt < 32) begin
          wl_a[wcnt] <= dmem_addr; wl_d[wcnt] <= dmem_wdata; wl_e[wcnt] <= cyc;
        end
        wcnt <= wcnt + 1;
      end
      cyc <= cyc + 1;
    end
  end

  function automatic logic [31:0] mv(input logic [7:0] d, input logic [7:0] s);
    return {8'hE0, d, s, 8'h00};
  endfunction
  function automatic logic [31:0] im(input logic [7:0] d, input logic [15:0] v);
    return {8'hD0, d, v};
  endfunction
  function automatic logic [31:0] tm(input logic [7:0] d, input logic [7:0] s);
    return {8'hA0, d, s, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic load_units;
    for (int i = 0; i < 64; i++) rom[i] = 32'h0;
    rom[0]  = im(8'h04, 16'h0100);
    rom[1]  = im(8'h41, 16'h1234);
    rom[2]  = mv(8'h05, 8'h41);
    rom[3]  = im(8'h0A, 16'h0007);
    rom[4]  = im(8'h0C, 16'h0005);
    rom[5]  = mv(8'h05, 8'h0B);
    rom[6]  = im(8'h13, 16'h0010);
    rom[7]  = im(8'h17, 16'h0011);
    rom[8]  = mv(8'h05, 8'h14);
    rom[9]  = im(8'h17, 16'h0010);
    rom[10] = mv(8'h05, 8'h14);
    rom[11] = im(8'h32, 16'h00FF);
    rom[12] = mv(8'h05, 8'h31);
    rom[13] = mv(8'h05, 8'h0C);
    rom[14] = im(8'h77, 16'h5555);
    rom[15] = mv(8'h05, 8'h77);
    rom[16] = mv(8'h05, 8'h41);
    rom[17] = im(8'h01, 16'h0001);
    rom[18] = tm(8'h05, 8'h41);
    rom[19] = im(8'h01, 16'h0002);
    rom[20] = tm(8'h05, 8'h0B);
    rom[21] = {8'h12, 8'h05, 8'h41, 8'h00};
    rom[22] = mv(8'h05, 8'h02);
    rom[23] = im(8'h02, 16'h0028);
    rom[24] = mv(8'h05, 8'h41);
    rom[40] = im(8'h04, 16'h0003);
    rom[41] = mv(8'h42, 8'h05);
    rom[42] = im(8'h04, 16'h0101);
    rom[43] = mv(8'h05, 8'h42);
    rom[44] = im(8'h02, 16'h002C);
  endtask

  task automatic load_sum;
    for (int i = 0; i < 64; i++) rom[i] = 32'h0;
    rom[0]  = im(8'h09, 16'h0030);
    rom[1]  = im(8'h03, 16'h0010);
    rom[16] = im(8'h31, 16'h0001);
    rom[17] = im(8'h41, 16'h0000);
    rom[18] = im(8'h42, 16'h0014);
    rom[19] = im(8'h13, 16'd10);
    rom[20] = mv(8'h0A, 8'h41);
    rom[21] = mv(8'h0C, 8'h31);
    rom[22] = mv(8'h41, 8'h0B);
    rom[23] = mv(8'h32, 8'h31);
    rom[24] = mv(8'h17, 8'h31);
    rom[25] = mv(8'h01, 8'h14);
    rom[26] = tm(8'h02, 8'h42);
    rom[27] = im(8'h04, 16'h8000);
    rom[28] = mv(8'h05, 8'h41);
    rom[29] = im(8'h02, 16'd29);
    rom[48] = im(8'h04, 16'h8001);
    rom[49] = mv(8'h05, 8'h08);
    rom[50] = mv(8'h03, 8'h08);
  endtask

  task automatic start;
    rst_n = 1'b0; irq = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int e);
    while (cyc != e) @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic finish_run;
    while (cyc < 400) @(negedge clk);
  endtask

  task automatic chk_sum(input string tag, input int n_int, input int s0, input int s1);
    chk(wcnt == n_int + 1, {tag, " store count"}, wcnt, n_int + 1);
    for (int i = 0; i < n_int; i++) begin
      chk(wl_a[i] == 16'h8001, {tag, " handler store address"}, wl_a[i], 32'h8001);
      chk(wl_d[i] == ((i == 0) ? s0 : s1), {tag, " saved return address"}, wl_d[i], (i == 0) ? s0 : s1);
    end
    chk(wl_a[n_int] == 16'h8000, {tag, " result address"}, wl_a[n_int], 32'h8000);
    chk(wl_d[n_int] == 32'd55, {tag, " sum 1..10"}, wl_d[n_int], 32'd55);
  endtask

  logic [15:0] ea [11];
  logic [31:0] ed [11];

  initial begin
    ea = '{16'h100, 16'h100, 16'h100, 16'h100, 16'h100, 16'h100,
           16'h100, 16'h100, 16'h100, 16'h100, 16'h101};
    ed[0] = 32'h1234;      ed[1] = 32'd7 + 32'd5;
    ed[2] = (32'h11 > 32'h10) ? 32'd1 : 32'd0;
    ed[3] = (32'h10 > 32'h10) ? 32'd1 : 32'd0;
    ed[4] = 32'hFF + 32'd1;
    ed[5] = 32'd0;         ed[6] = 32'd0;
    ed[7] = 32'h1234;      ed[8] = 32'd12;
    ed[9] = 32'd22;        ed[10] = 32'hCAFEF00D;

    load_units;
    start;
    chk(rom_addr == 0, "R5 reset fetch address", rom_addr, 0);
    chk(dmem_we == 1'b0, "R5 reset store strobe", dmem_we, 0);
    finish_run;
    chk(wcnt == 11, "R3/R4/R6 store count (suppressed, unknown, skipped)", wcnt, 11);
    for (int i = 0; i < 11; i++) begin
      chk(wl_a[i] == ea[i], "R10 store address", wl_a[i], ea[i]);
      chk(wl_d[i] == ed[i], "R1 R2 R7 R8 R9 R4 R3 R6 R10 store value", wl_d[i], ed[i]);
    end
    chk(wl_e[0] == 2*2 + 1, "R5 execute edge of instruction 2", wl_e[0], 5);
    chk(wl_e[10] == 2*27 + 1, "R6 execute edge after jump", wl_e[10], 55);

    load_sum;  start; finish_run;
    chk_sum("R6 R7 R8 R9 no interrupt", 0, 0, 0);
    load_sum;  start; pulse(58); finish_run;
    chk_sum("R11 mid-loop interrupt", 1, 23, 0);
    load_sum;  start; pulse(0); finish_run;
    chk_sum("R12 request held through setup", 1, 17, 0);
    load_sum;  start; pulse(58); pulse(62); finish_run;
    chk_sum("R12 request held through handler", 2, 23, 24);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule